// File: doc/BRIEF.md
# Tape music-pause detector

This block finds the silent gaps between songs while a tape is wound at high speed. Each time the sample enable is high it takes one signed sample from each of the two audio channels. It takes the magnitude of each sample, adds the two magnitudes, and smooths the sum into an envelope. A comparator with hysteresis turns the envelope into a loud/quiet flag. Two timers, driven by a 1 ms tick enable, then qualify the flag in time. Loudness must last a rise time before the status output goes high. Quietness must last a selectable delay before the output goes low.

Two detection modes are provided. Scan mode is for a controller that reads the status directly. Latch mode is for a simple motor driver: it keeps the output high from mode entry until music has first been qualified, so a blank stretch of tape cannot stop the transport early. While either mode is active, the block asks the surrounding audio path to bypass noise reduction.

Top module: `music_pause_detector`

## Requirements
- R1: In reset, and whenever the mode select is inactive (2'b00 or 2'b11), music_o is 1 and nr_bypass_o is 0. An inactive mode also clears both timers and re-arms the latch on the next clock.
- R2: nr_bypass_o is 1 while the mode select is 2'b01 (scan) or 2'b10 (latch).
- R3: On every cycle with sample_en_i high, env becomes env - (env >> 2) + ((|left_i| + |right_i|) >> 2). The magnitudes are taken before the addition, so a right channel that is the inverse of the left channel still counts as signal.
- R4: The loud flag sets when env >= 1460 and clears when env < 1301, and keeps its value between the two. The two thresholds are REF_LEVEL*5840/65536 and REF_LEVEL*5204/65536, with REF_LEVEL = 16384, which is about 21 dB and 22 dB below the reference level.
- R5: While music_o is low, music_o goes high on the N-th consecutive tick with the loud flag set. N is 6 in scan mode and 150 in latch mode. A loud burst of fewer ticks leaves music_o low.
- R6: While music_o is high, music_o goes low on the D-th consecutive tick with the loud flag clear. A quiet gap of fewer ticks leaves music_o unchanged.
- R7: D is selected by delay_sel_i. Codes 0 to 10 give 23, 42, 48, 56, 65, 76, 98, 112, 126, 142 and 160 ms. Codes above 10 give 160 ms.
- R8: On entry to scan mode, music_o starts high. If the input stays quiet, music_o falls after D ticks. If music is present at entry, music_o stays high.
- R9: In latch mode, music_o is held high from mode entry until a loud run of 150 ticks has been qualified. After that, music_o follows R5 and R6.
- R10: A direct change between scan and latch restarts the block as in R1: the timers clear, the latch re-arms and the qualified state is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_en_i | input | 1 | Sample valid enable |
| left_i | input | 16 | Left channel sample, signed |
| right_i | input | 16 | Right channel sample, signed |
| tick_ms_i | input | 1 | 1 ms timer enable, one clock wide |
| mode_i | input | 2 | 01 scan, 10 latch, others inactive |
| delay_sel_i | input | 4 | Pause delay code |
| music_o | output | 1 | High for music, low for a found pause |
| nr_bypass_o | output | 1 | Noise reduction bypass request |

## Verification
The assertions assume that tick_ms_i is a single-cycle pulse and that the mode select changes only between clock edges. Under that assumption, every change of music_o while the mode is held steady can be traced back to a tick and to the loud flag in the previous cycle. The stimulus changes samples and mode only just after a tick, and it keeps a long gap between ticks. Its loud amplitudes and quiet levels are chosen so that the envelope settles across a threshold well before the next tick, so every millisecond sees one constant loud or quiet value.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_SCAN  = 2'b01,
    MODE_LATCH = 2'b10,
    MODE_SPARE = 2'b11
  } mode_e;

  // pause delay in ms per select code; codes above 10 saturate
  function automatic int unsigned pause_delay_ms(input logic [3:0] sel);
    case (sel)
      4'd0:    return 23;
      4'd1:    return 42;
      4'd2:    return 48;
      4'd3:    return 56;
      4'd4:    return 65;
      4'd5:    return 76;
      4'd6:    return 98;
      4'd7:    return 112;
      4'd8:    return 126;
      4'd9:    return 142;
      default: return 160;
    endcase
  endfunction
endpackage

// File: rtl/mpd_envelope.sv
module mpd_envelope #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned SHIFT    = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sample_en_i,
  input  logic signed [SAMPLE_W-1:0] left_i,
  input  logic signed [SAMPLE_W-1:0] right_i,
  output logic        [SAMPLE_W:0]   env_o
);
  localparam int unsigned ENV_W = SAMPLE_W + 1;

  logic signed [SAMPLE_W-1:0] smp [2];
  logic        [SAMPLE_W-1:0] mag [2];
  logic        [ENV_W-1:0]    sum;
  logic        [ENV_W-1:0]    env_q;

  assign smp[0] = left_i;
  assign smp[1] = right_i;

  for (genvar c = 0; c < 2; c++) begin : g_rect
    assign mag[c] = smp[c][SAMPLE_W-1] ? SAMPLE_W'(-smp[c]) : SAMPLE_W'(smp[c]);
  end

  assign sum = ENV_W'(mag[0]) + ENV_W'(mag[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          env_q <= '0;
    else if (sample_en_i) env_q <= env_q - (env_q >> SHIFT) + (sum >> SHIFT);
  end

  assign env_o = env_q;
endmodule

// File: rtl/mpd_level.sv
module mpd_level #(
  parameter int unsigned ENV_W  = 17,
  parameter int unsigned THR_HI = 1460,
  parameter int unsigned THR_LO = 1301
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ENV_W-1:0] env_i,
  output logic             loud_o
);
  localparam logic [ENV_W-1:0] HI = ENV_W'(THR_HI);
  localparam logic [ENV_W-1:0] LO = ENV_W'(THR_LO);

  logic loud_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      loud_q <= 1'b0;
    else if (!loud_q && env_i >= HI)  loud_q <= 1'b1;
    else if (loud_q && env_i < LO)    loud_q <= 1'b0;
  end

  assign loud_o = loud_q;
endmodule

// File: rtl/mpd_qualifier.sv
module mpd_qualifier #(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned RISE_SCAN  = 6,
  parameter int unsigned RISE_LATCH = 150
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             latch_mode_i,
  input  logic             tick_i,
  input  logic             loud_i,
  input  logic [CNT_W-1:0] delay_i,
  output logic             qual_o,
  output logic             latch_o
);
  localparam logic [CNT_W-1:0] RISE_SCAN_M1  = CNT_W'(RISE_SCAN - 1);
  localparam logic [CNT_W-1:0] RISE_LATCH_M1 = CNT_W'(RISE_LATCH - 1);

  logic             qual_q, latch_q;
  logic [CNT_W-1:0] rise_cnt, pause_cnt;
  logic [CNT_W-1:0] rise_last, pause_last;
  logic             rise_run, pause_run, rise_done, pause_done;

  assign rise_last  = latch_mode_i ? RISE_LATCH_M1 : RISE_SCAN_M1;
  assign pause_last = delay_i - 1'b1;
  // latch keeps the rise timer armed even while qualified
  assign rise_run   = loud_i && (!qual_q || (latch_mode_i && latch_q));
  assign pause_run  = !loud_i && qual_q;
  assign rise_done  = rise_run && tick_i && (rise_cnt == rise_last);
  assign pause_done = pause_run && tick_i && (pause_cnt == pause_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qual_q    <= 1'b1;
      latch_q   <= 1'b1;
      rise_cnt  <= '0;
      pause_cnt <= '0;
    end else if (restart_i) begin
      qual_q    <= 1'b1;
      latch_q   <= 1'b1;
      rise_cnt  <= '0;
      pause_cnt <= '0;
    end else begin
      if (!rise_run || rise_done) rise_cnt <= '0;
      else if (tick_i)            rise_cnt <= rise_cnt + 1'b1;

      if (!pause_run || pause_done) pause_cnt <= '0;
      else if (tick_i)              pause_cnt <= pause_cnt + 1'b1;

      if (rise_done) begin
        qual_q  <= 1'b1;
        latch_q <= 1'b0;
      end else if (pause_done) begin
        qual_q  <= 1'b0;
      end
    end
  end

  assign qual_o  = qual_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/music_pause_detector.sv
module music_pause_detector #(
  parameter int unsigned SAMPLE_W      = 16,
  parameter int unsigned ENV_SHIFT     = 2,
  parameter int unsigned REF_LEVEL     = 16384,
  parameter int unsigned HI_Q16        = 5840,
  parameter int unsigned LO_Q16        = 5204,
  parameter int unsigned RISE_SCAN_MS  = 6,
  parameter int unsigned RISE_LATCH_MS = 150,
  parameter int unsigned CNT_W         = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sample_en_i,
  input  logic signed [SAMPLE_W-1:0] left_i,
  input  logic signed [SAMPLE_W-1:0] right_i,
  input  logic                       tick_ms_i,
  input  logic [1:0]                 mode_i,
  input  logic [3:0]                 delay_sel_i,
  output logic                       music_o,
  output logic                       nr_bypass_o
);
  import mpd_pkg::*;

  localparam int unsigned       ENV_W   = SAMPLE_W + 1;
  localparam longint unsigned   PROD_HI = longint'(REF_LEVEL) * longint'(HI_Q16);
  localparam longint unsigned   PROD_LO = longint'(REF_LEVEL) * longint'(LO_Q16);
  localparam int unsigned       THR_HI  = int'(PROD_HI >> 16);
  localparam int unsigned       THR_LO  = int'(PROD_LO >> 16);

  mode_e            mode, mode_q;
  logic             active, latch_mode, restart;
  logic [ENV_W-1:0] env;
  logic             loud;
  logic             qual_st, latch_st;
  logic [CNT_W-1:0] delay_ms;

  assign mode       = mode_e'(mode_i);
  assign active     = (mode == MODE_SCAN) || (mode == MODE_LATCH);
  assign latch_mode = (mode == MODE_LATCH);
  assign restart    = !active || (mode != mode_q);
  assign delay_ms   = CNT_W'(pause_delay_ms(delay_sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_IDLE;
    else         mode_q <= mode;
  end

  mpd_envelope #(.SAMPLE_W(SAMPLE_W), .SHIFT(ENV_SHIFT)) u_env (
    .clk_i, .rst_ni, .sample_en_i, .left_i, .right_i, .env_o(env)
  );

  mpd_level #(.ENV_W(ENV_W), .THR_HI(THR_HI), .THR_LO(THR_LO)) u_level (
    .clk_i, .rst_ni, .env_i(env), .loud_o(loud)
  );

  mpd_qualifier #(
    .CNT_W(CNT_W), .RISE_SCAN(RISE_SCAN_MS), .RISE_LATCH(RISE_LATCH_MS)
  ) u_qual (
    .clk_i, .rst_ni,
    .restart_i   (restart),
    .latch_mode_i(latch_mode),
    .tick_i      (tick_ms_i),
    .loud_i      (loud),
    .delay_i     (delay_ms),
    .qual_o      (qual_st),
    .latch_o     (latch_st)
  );

  assign music_o     = !active || qual_st || (latch_mode && latch_st);
  assign nr_bypass_o = active;
endmodule

// File: rtl/mpd_checker.sv
module mpd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       tick_ms_i,
  input logic       music_o,
  input logic       nr_bypass_o,
  input logic       loud_i,
  input logic       qual_i,
  input logic       latch_i
);
  logic active;
  assign active = (mode_i == 2'b01) || (mode_i == 2'b10);

  assert_pause_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(music_o) && $stable(mode_i) && (mode_i == $past(mode_i, 2))
      |-> $past(tick_ms_i) && !$past(loud_i));

  assert_music_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(music_o) && $stable(mode_i) && (mode_i == $past(mode_i, 2))
      |-> $past(tick_ms_i) && $past(loud_i));

  assert_idle_rearm_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> qual_i && latch_i);

  assert_latch_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(latch_i) && (mode_i == 2'b10) && $stable(mode_i)
      |-> $past(loud_i) && $past(tick_ms_i));

  assert_entry_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nr_bypass_o) |-> music_o);
endmodule

bind music_pause_detector mpd_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .tick_ms_i  (tick_ms_i),
  .music_o    (music_o),
  .nr_bypass_o(nr_bypass_o),
  .loud_i     (loud),
  .qual_i     (qual_st),
  .latch_i    (latch_st)
);

// File: tb/tb_music_pause_detector.sv
module tb_music_pause_detector;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 16;
  localparam int WATCHDOG   = 190000;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               sample_en_i = 1'b1;
  logic signed [15:0] left_i = '0;
  logic signed [15:0] right_i = '0;
  logic               tick_ms_i = 1'b0;
  logic [1:0]         mode_i = 2'b00;
  logic [3:0]         delay_sel_i = 4'd0;
  logic               music_o, nr_bypass_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  bit m_q = 1, m_latch = 1;
  int m_rc = 0, m_pc = 0, m_mode = 0;

  music_pause_detector dut (
    .clk_i(clk), .rst_ni, .sample_en_i, .left_i, .right_i,
    .tick_ms_i, .mode_i, .delay_sel_i, .music_o, .nr_bypass_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk);
      #1;
      cnt = (cnt == TICK_DIV-1) ? 0 : cnt + 1;
      tick_ms_i = (cnt == 0);
    end
  end

  function automatic int dly_of(int sel);
    case (sel)
      0: return 23;   1: return 42;   2: return 48;  3: return 56;
      4: return 65;   5: return 76;   6: return 98;  7: return 112;
      8: return 126;  9: return 142;  default: return 160;
    endcase
  endfunction

  function automatic bit is_active(int m);
    return (m == 1) || (m == 2);
  endfunction

  function automatic bit exp_music();
    return !is_active(m_mode) || m_q || (m_mode == 2 && m_latch);
  endfunction

  task automatic model_restart();
    m_q = 1; m_latch = 1; m_rc = 0; m_pc = 0;
  endtask

  task automatic model_tick(bit loud);
    int lim;
    int dl;
    bit need, nq, nl;
    if (!is_active(m_mode)) return;
    lim  = (m_mode == 2) ? 150 : 6;
    dl   = dly_of(int'(delay_sel_i));
    need = !m_q || (m_mode == 2 && m_latch);
    nq = m_q; nl = m_latch;
    if (loud && need) begin
      if (m_rc == lim-1) begin m_rc = 0; nq = 1; nl = 0; end
      else m_rc++;
    end else m_rc = 0;
    if (!loud && m_q) begin
      if (m_pc == dl-1) begin m_pc = 0; nq = 0; end
      else m_pc++;
    end else m_pc = 0;
    m_q = nq; m_latch = nl;
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick_ms_i);
    @(negedge clk);
  endtask

  task automatic set_mode(int m);
    mode_i = m[1:0];
    if (m != m_mode || !is_active(m)) model_restart();
    m_mode = m;
  endtask

  task automatic seg(int l, int r, bit loud, int ms);
    left_i  = 16'(l);
    right_i = 16'(r);
    repeat (ms) begin
      wait_tick();
      model_tick(loud);
    end
  endtask

  task automatic loud_seg(int ms);  seg(10000, -9000, 1, ms); endtask
  task automatic quiet_seg(int ms); seg(40, -30, 0, ms);      endtask

  function automatic int rnd_amp(int lo, int hi);
    int a;
    a = lo + int'($urandom % (hi - lo + 1));
    return ($urandom & 1) ? -a : a;
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 reset music", music_o, 1'b1);
    chk("R1 reset bypass", nr_bypass_o, 1'b0);
    rst_ni = 1'b1;
    wait_tick();

    // scan entry, silent
    set_mode(1);
    #1;
    chk("R2 scan bypass", nr_bypass_o, 1'b1);
    chk("R8 scan entry high", music_o, 1'b1);
    quiet_seg(22);  chk("R8 before delay", music_o, 1'b1);
    quiet_seg(1);   chk("R8 pause found", music_o, 1'b0);

    // rise qualification
    loud_seg(5);    chk("R5 short burst", music_o, 1'b0);
    quiet_seg(30);
    loud_seg(6);    chk("R5 rise time", music_o, 1'b1);

    // pause qualification
    quiet_seg(22);  chk("R6 short gap", music_o, 1'b1);
    loud_seg(3);
    quiet_seg(23);  chk("R6 full delay", music_o, 1'b0);

    // rectification
    seg(800, -800, 1, 6);  chk("R3 inverted channels", music_o, 1'b1);
    quiet_seg(23);
    seg(300, -300, 0, 20); chk("R3 below threshold", music_o, 1'b0);

    // hysteresis
    seg(690, -690, 0, 20); chk("R4 mid from quiet", music_o, 1'b0);
    loud_seg(6);
    seg(690, -690, 1, 40); chk("R4 mid from loud", music_o, 1'b1);
    quiet_seg(23);         chk("R4 quiet after mid", music_o, 1'b0);

    // delay table
    delay_sel_i = 4'd10;
    loud_seg(6); quiet_seg(159); chk("R7 code 10 early", music_o, 1'b1);
    quiet_seg(1);                chk("R7 code 10", music_o, 1'b0);
    delay_sel_i = 4'd15;
    loud_seg(6); quiet_seg(159); chk("R7 code 15 early", music_o, 1'b1);
    quiet_seg(1);                chk("R7 code 15", music_o, 1'b0);
    delay_sel_i = 4'd5;
    loud_seg(6); quiet_seg(75);  chk("R7 code 5 early", music_o, 1'b1);
    quiet_seg(1);                chk("R7 code 5", music_o, 1'b0);

    // scan entry with music present
    set_mode(0);
    #1;
    chk("R1 idle music", music_o, 1'b1);
    chk("R1 idle bypass", nr_bypass_o, 1'b0);
    set_mode(1);
    loud_seg(200);  chk("R8 entry with music", music_o, 1'b1);
    quiet_seg(1);

    // latch mode
    delay_sel_i = 4'd0;
    set_mode(0);
    @(negedge clk);
    set_mode(2);
    #1;
    chk("R2 latch bypass", nr_bypass_o, 1'b1);
    quiet_seg(300); chk("R9 latch holds on blank", music_o, 1'b1);
    loud_seg(100);
    quiet_seg(200); chk("R9 latch holds after burst", music_o, 1'b1);
    loud_seg(150);
    quiet_seg(22);  chk("R9 released early", music_o, 1'b1);
    quiet_seg(1);   chk("R9 released pause", music_o, 1'b0);
    loud_seg(149);  chk("R5 latch rise short", music_o, 1'b0);
    loud_seg(1);    chk("R5 latch rise", music_o, 1'b1);
    quiet_seg(23);  chk("R6 latch pause", music_o, 1'b0);

    // direct mode changes
    set_mode(1);
    @(negedge clk);
    chk("R10 latch to scan high", music_o, 1'b1);
    quiet_seg(22);  chk("R10 timer cleared", music_o, 1'b1);
    quiet_seg(1);   chk("R10 scan pause", music_o, 1'b0);
    set_mode(2);
    quiet_seg(300); chk("R10 latch rearmed", music_o, 1'b1);

    // constrained random segments checked against the model
    set_mode(1);
    for (int i = 0; i < 30; i++) begin
      int len;
      if ($urandom % 8 == 0) set_mode(($urandom & 1) ? 2 : 1);
      delay_sel_i = 4'($urandom % 16);
      len = 1 + int'($urandom % 180);
      if ($urandom & 1) seg(rnd_amp(4000, 12000), rnd_amp(4000, 12000), 1, len);
      else              seg(rnd_amp(0, 200), rnd_amp(0, 200), 0, len);
      chk("R5 R6 random", music_o, exp_music());
    end

    summary();
  end
endmodule